// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches a set of external interrupt pins and turns selected conditions on them into interrupt requests for a processor. Each pin passes through a synchroniser. It is then judged against its own sense setting, which can be active-low level, active-high level, rising edge, falling edge or both edges. A detection is caught in a sticky status bit that software clears by writing ones.

Each line has an enable bit. Software sets enable bits through one address and clears them through another, so no read-modify-write is needed. Each line drives its own registered interrupt output, equal to its status bit gated by its enable. A plain 32-bit register bus gives access to the registers. A read returns data one cycle after the request, flagged by a valid strobe. A monitor register shows the synchronised pin levels.

In the usual service flow, software reads the status, clears the bit it is about to handle, and then services that line. For level senses, the status bit is set again on every clock while the level stays active. Clearing it therefore only sticks once the pin has gone inactive.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, every enable bit, every status bit and every line's sense field is zero, all interrupt outputs are low, and reads of those registers return zero.
- R2: Line n's sense field sits at byte offset 0x180 + 4*n. Only its low 6 bits are stored, and they read back at the same offset. Bit 0 selects low level, bit 1 high level, bit 2 falling edge and bit 3 rising edge, so 0x0C detects both edges. Bits 4 and 5 are stored but select nothing.
- R3: A line whose sense field has none of bits 0 to 3 set never sets its status bit or its interrupt, whatever its pin does.
- R4: Edge detection runs on the synchronised pin in the block clock. A single edge of the selected polarity sets the status bit, which stays set after the pin returns. An edge of the other polarity does not set it.
- R5: The status register at 0x100 (bit n = line n) is cleared only by writing 1 to a bit. Bits written with 0 are unchanged.
- R6: For a level sense, the status bit is set on every clock while the level is active, so a clear written during that time leaves it set. Once the pin is inactive, a clear sticks.
- R7: Writing 1 to a bit at 0x08 sets that line's enable, and writing 1 to a bit at 0x04 clears it. Bits written with 0 are unchanged. Reads of 0x04 return the enable mask.
- R8: Reads of 0x00 return status AND enable. Output irq_out[n] carries that bit one clock later: it rises on the fourth rising clock edge after a detecting pin change is first sampled.
- R9: Reads of 0x104 return the pin levels after the two-stage synchroniser.
- R10: Bits for lines at or above NUM_LINES read as zero. Sense offsets beyond the last line, and any other unmapped offset, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pin_in | input | NUM_LINES | Asynchronous external interrupt pins |
| irq_out | output | NUM_LINES | Registered per-line interrupt requests |

## Verification
A pin change driven just after a falling clock edge sets the status bit three rising edges later and the interrupt output four rising edges later. The bench therefore samples irq_out one falling edge before and one after that fourth rising edge, to pin the latency down exactly. Register reads complete on the rising edge after the request. The driver queues each expected read value when it issues the request, and the monitor pops and compares it on the falling edge at which the read valid strobe is seen. Before status or monitor values are read back, the bench waits at least five clocks after a pin change, so the synchroniser and detector have settled. Effects of writes on the outputs are checked one clock after the write has taken effect.

// File: rtl/eid_pkg.sv
package eid_pkg;
  localparam int CFG_W = 6;

  // sense field bit positions
  localparam int SNS_LOW  = 0;
  localparam int SNS_HIGH = 1;
  localparam int SNS_FALL = 2;
  localparam int SNS_RISE = 3;

  // register byte offsets
  localparam int OFS_REQ   = 'h000;
  localparam int OFS_ENCLR = 'h004;
  localparam int OFS_ENSET = 'h008;
  localparam int OFS_STAT  = 'h100;
  localparam int OFS_MON   = 'h104;
  localparam int OFS_CFG   = 'h180;
endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eid_line.sv
module eid_line
  import eid_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             clr,
  output logic [CFG_W-1:0] cfg_q,
  output logic             stat_q
);
  logic prev_q;
  logic det;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      prev_q <= lvl;
      // a new detection wins over a clear in the same cycle
      stat_q <= det | (stat_q & ~clr);
    end
  end

  always_comb begin
    det = (cfg_q[SNS_LOW]  & ~lvl)
        | (cfg_q[SNS_HIGH] &  lvl)
        | (cfg_q[SNS_FALL] &  prev_q & ~lvl)
        | (cfg_q[SNS_RISE] & ~prev_q &  lvl);
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import eid_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [ADDR_W-1:0] A_REQ   = ADDR_W'(OFS_REQ);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFS_ENCLR);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFS_ENSET);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_MON   = ADDR_W'(OFS_MON);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(4 * NUM_LINES);

  logic                       wr_en, rd_en;
  logic [ADDR_W-1:0]          cfg_off;
  logic                       cfg_hit;
  logic [IDX_W-1:0]           cfg_idx;
  logic [NUM_LINES-1:0]       wmask;
  logic [NUM_LINES-1:0]       sync_lvl;
  logic [NUM_LINES-1:0]       en_q;
  logic [NUM_LINES-1:0]       stat_q;
  logic [NUM_LINES-1:0]       clr_vec;
  logic [NUM_LINES-1:0]       req;
  logic [CFG_W-1:0]           cfg_arr [NUM_LINES];
  logic [NUM_LINES*CFG_W-1:0] cfg_flat;
  logic [DATA_W-1:0]          rd_mux;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;
  assign wmask = bus_wdata[NUM_LINES-1:0];

  always_comb begin
    cfg_off = bus_addr - A_CFG;
    cfg_hit = (bus_addr >= A_CFG) && (cfg_off < CFG_SPAN) && (cfg_off[1:0] == 2'b00);
    cfg_idx = cfg_off[IDX_W+1:2];
  end

  eid_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (sync_lvl)
  );

  assign clr_vec = (wr_en && bus_addr == A_STAT) ? wmask : '0;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    eid_line u_line (
      .clk       (clk),
      .rst       (rst),
      .lvl       (sync_lvl[n]),
      .cfg_we    (wr_en && cfg_hit && (cfg_idx == IDX_W'(n))),
      .cfg_wdata (bus_wdata[CFG_W-1:0]),
      .clr       (clr_vec[n]),
      .cfg_q     (cfg_arr[n]),
      .stat_q    (stat_q[n])
    );
    assign cfg_flat[n*CFG_W +: CFG_W] = cfg_arr[n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_en && bus_addr == A_ENSET) begin
      en_q <= en_q | wmask;
    end else if (wr_en && bus_addr == A_ENCLR) begin
      en_q <= en_q & ~wmask;
    end
  end

  assign req = stat_q & en_q;

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= req;
  end

  always_comb begin
    rd_mux = '0;
    if (cfg_hit) begin
      rd_mux[CFG_W-1:0] = cfg_arr[cfg_idx];
    end else begin
      case (bus_addr)
        A_REQ:   rd_mux[NUM_LINES-1:0] = req;
        A_ENCLR: rd_mux[NUM_LINES-1:0] = en_q;
        A_STAT:  rd_mux[NUM_LINES-1:0] = stat_q;
        A_MON:   rd_mux[NUM_LINES-1:0] = sync_lvl;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/eid_chk.sv
module eid_chk
  import eid_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_sel,
  input logic                       bus_wr,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [NUM_LINES-1:0]       irq_out,
  input logic [NUM_LINES-1:0]       en_q,
  input logic [NUM_LINES-1:0]       stat_q,
  input logic [NUM_LINES*CFG_W-1:0] cfg_flat
);
  logic [NUM_LINES-1:0] cfg_zero;
  logic [NUM_LINES-1:0] wm;
  logic                 w_set, w_clr, w_stat;

  always_comb begin
    for (int n = 0; n < NUM_LINES; n++)
      cfg_zero[n] = (cfg_flat[n*CFG_W +: 4] == 4'b0000);
  end

  assign wm     = bus_wdata[NUM_LINES-1:0];
  assign w_set  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_ENSET));
  assign w_clr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_ENCLR));
  assign w_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_STAT));

  AST_SET_ENABLES: assert property (@(posedge clk) disable iff (rst)
    w_set |=> ((en_q & $past(wm)) == $past(wm))); // R7
  AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (rst)
    w_clr |=> ((en_q & $past(wm)) == '0)); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !w_stat |=> ((~stat_q & $past(stat_q)) == '0)); // R5
  AST_ZERO_CFG_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~$past(stat_q) & $past(cfg_zero)) == '0)); // R3
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ((irq_out & ~$past(en_q)) == '0)); // R8
  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (rst)
    ((irq_out & ~$past(stat_q)) == '0)); // R8
endmodule

bind ext_irq_detect eid_chk #(
  .NUM_LINES (NUM_LINES),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_out   (irq_out),
  .en_q      (en_q),
  .stat_q    (stat_q),
  .cfg_flat  (cfg_flat)
);

// File: tb/ext_irq_detect_tb.sv
module ext_irq_detect_tb;
  localparam int N  = 8;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [N-1:0]  pins = '0;
  logic [N-1:0]  irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #10 clk = ~clk;

  ext_irq_detect #(.NUM_LINES(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pin_in     (pins),
    .irq_out    (irq_out)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // driver side of the scoreboard: queue the expected read value
  task automatic bus_read(input int addr, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(addr);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        chk("unexpected read data", bus_rdata, 32'hxxxx_xxxx);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R1 irq_out after reset", DW'(irq_out), 0);
    bus_read('h004, 0, "R1 enable mask after reset");
    bus_read('h100, 0, "R1 status after reset");
    bus_read('h188, 0, "R1 sense field after reset");

    // sense fields: 0 rise, 1 fall, 2 both, 3 high, 4 low, 5 none, 7 spare bits only
    bus_write('h180, 'h08);
    bus_write('h184, 'h04);
    bus_write('h188, 'h0C);
    bus_write('h18C, 'h02);
    bus_write('h190, 'h01);
    bus_write('h19C, 'hF0);
    bus_read('h188, 'h0C, "R2 both-edge sense readback");
    bus_read('h19C, 'h30, "R2 only 6 bits stored");
    bus_read('h100, 'h10, "R6 low level with pin low sets status");

    bus_write('h008, 'h3F);
    bus_read('h004, 'h3F, "R7 enable set");
    bus_write('h004, 'h20);
    bus_read('h004, 'h1F, "R7 enable clear, zero bits kept");
    idle(1);
    chk("R8 irq for enabled level line", DW'(irq_out), 'h10);
    bus_read('h000, 'h10, "R8 request register");

    bus_write('h100, 'h10);
    bus_read('h100, 'h10, "R6 clear while level active does not stick");
    pins[4] = 1'b1;
    idle(4);
    bus_write('h100, 'h10);
    bus_read('h100, 0, "R6 clear sticks after level inactive");
    chk("R8 irq drops after clear", DW'(irq_out), 0);

    // rising edge on line 0: exact latency
    pins[0] = 1'b1;
    idle(3);
    chk("R8 irq not yet after 3 edges", DW'(irq_out), 0);
    idle(1);
    chk("R8 irq after 4 edges", DW'(irq_out), 'h01);
    pins[0] = 1'b0;
    idle(5);
    bus_read('h100, 'h01, "R4 rising edge latched after pin returns");

    pins[1] = 1'b1;
    idle(5);
    bus_read('h100, 'h01, "R4 rising edge ignored on falling line");
    pins[1] = 1'b0;
    idle(5);
    bus_read('h100, 'h03, "R4 falling edge detected");

    bus_write('h100, 'h02);
    bus_read('h100, 'h01, "R5 write one clears one bit");
    bus_write('h100, 'h00);
    bus_read('h100, 'h01, "R5 write zero changes nothing");
    bus_write('h100, 'h01);
    bus_read('h100, 'h00, "R5 last bit cleared");

    pins[2] = 1'b1;
    idle(5);
    bus_read('h100, 'h04, "R2 both-edge line sees rise");
    bus_write('h100, 'h04);
    pins[2] = 1'b0;
    idle(5);
    bus_read('h100, 'h04, "R2 both-edge line sees fall");
    bus_write('h100, 'h04);

    pins[3] = 1'b1;
    idle(5);
    bus_read('h100, 'h08, "R2 high level detected");
    bus_write('h100, 'h08);
    bus_read('h100, 'h08, "R6 high level re-sets after clear");
    pins[3] = 1'b0;
    idle(5);
    bus_write('h100, 'h08);
    bus_read('h100, 0, "R6 high level cleared once low");

    pins[5] = 1'b1; pins[7] = 1'b1;
    idle(5);
    pins[5] = 1'b0; pins[7] = 1'b0;
    idle(5);
    bus_read('h100, 0, "R3 zero sense field detects nothing");
    chk("R3 no irq from unsensed lines", DW'(irq_out), 0);

    pins[6] = 1'b1;
    idle(3);
    bus_read('h104, 'h50, "R9 monitor shows synchronised pins");

    bus_write('h004, 'h01);
    pins[0] = 1'b1;
    idle(5);
    chk("R7 disabled line gives no irq", DW'(irq_out), 0);
    bus_read('h000, 0, "R8 request masked by enable");
    bus_read('h100, 'h01, "R7 status latched while disabled");
    bus_write('h008, 'h01);
    idle(1);
    chk("R8 irq after re-enable", DW'(irq_out), 'h01);
    bus_read('h000, 'h01, "R8 request after re-enable");

    bus_write('h008, 32'hFFFF_FFFF);
    bus_read('h004, 'hFF, "R10 enable bits above lines read zero");
    bus_write('h1A0, 'h08);
    bus_read('h1A0, 0, "R10 sense offset past last line");
    bus_read('h00C, 0, "R10 unmapped offset");

    idle(3);
    chk("scoreboard drained", DW'(exp_q.size()), 0);
    summary();
  end
endmodule